// File: doc/BRIEF.md
# Exception Entry Priority Controller

This block decides which exception a small processor core takes on each cycle. It samples seven kinds of request: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software call. It weighs them against the interrupt mask bits of its own status register. Each entry it takes is reported as a one-cycle take strobe, together with the handler vector, the new processor mode and the updated mask bits.

The block holds the live status register, which has a 5-bit mode and two mask bits. It also holds one saved copy of that register for each privileged mode. On entry, the old status is written into the saved copy that belongs to the mode being entered. A return strobe copies the saved status of the current mode back into the live register in one step.

A data abort that arrives together with an enabled fast interrupt is taken first. The fast interrupt entry then follows on the very next cycle, so the abort context is saved in the fast interrupt's copy and comes back when that handler returns. Request lines are level-sensitive. A request that loses arbitration and is still asserted is taken on a later cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Reset is asynchronous and active low. While it is asserted, the outputs show mode 0x13 with both mask bits set and no take. On the first clock edge after release, the block makes a reset entry at vector 0x00. This reset entry overrides any chained fast interrupt entry that was outstanding.
- R2: The vector of each entry is:
  - reset 0x00
  - undefined instruction 0x04
  - software call 0x08
  - prefetch abort 0x0C
  - data abort 0x10
  - normal interrupt 0x18
  - fast interrupt 0x1C
- R3: The mode on entry is:
  - 0x13 (supervisor) for reset and software call
  - 0x1B for undefined instruction
  - 0x17 for either abort
  - 0x12 for the normal interrupt
  - 0x11 for the fast interrupt

  Mode 0x10 is user mode. Every entry sets the I mask. Only reset and fast interrupt entries set the F mask; other entries leave F unchanged.
- R4: When several requests are active, the order from highest to lowest is reset, data abort, fast interrupt, normal interrupt, prefetch abort, then undefined instruction or software call.
- R5: A fast interrupt request is ignored while F is set. A normal interrupt request is ignored while I is set.
- R6: If a data abort and a fast interrupt with F clear arrive in the same cycle, the data abort entry is taken first. The fast interrupt entry follows on the next cycle, even if the fast interrupt request has dropped.
- R7: On every entry except reset, the status that was live before the entry is stored in the saved copy that belongs to the mode being entered.
- R8: A return strobe loads the saved copy of the current mode into the live status in one cycle. A return strobe is ignored in user mode, and it is ignored in any cycle that makes an entry.
- R9: A lower-priority request that loses arbitration, and is still asserted on a later cycle with no higher-priority request, is taken then.
- R10: The reserved vector 0x14 is never output.
- R11: Outputs are registered. A request sampled at one clock edge shows up as a take strobe that lasts one cycle after that edge, with one strobe per entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software call request |
| exc_ret | input | 1 | Return strobe, restores saved status |
| take_o | output | 1 | Entry strobe, one cycle per entry |
| vec_o | output | VEC_W | Handler vector of the last entry |
| mode_o | output | 5 | Live processor mode |
| imask_o | output | 1 | Live normal-interrupt mask |
| fmask_o | output | 1 | Live fast-interrupt mask |

## Verification
The bench concentrates on the following corner cases:
- **Data abort together with an enabled fast interrupt.** A design that dropped the chained entry would lose the fast interrupt. A design that saved the wrong status would return to user mode instead of the abort context.
- **Masked interrupts.** A design that ignored the mask bits would enter a handler while the masks forbid it.
- **Losing requests that stay asserted.** A design that latched and then forgot such a request would never serve it.
- **Reset arriving between the two halves of a chain.** A design that kept the chain flag would take the fast interrupt vector instead of 0x00.

Random request mixes with random return strobes are compared against a bench model of the priority, masking and status rules.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [4:0] {
        M_USR = 5'h10,
        M_FIQ = 5'h11,
        M_IRQ = 5'h12,
        M_SVC = 5'h13,
        M_ABT = 5'h17,
        M_UND = 5'h1B
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  i;
        logic  f;
    } psr_t;

    typedef enum logic [2:0] {
        X_NONE, X_RST, X_DABT, X_FIQ, X_IRQ, X_PABT, X_UND, X_SWI
    } exc_e;

    localparam int NBANK = 5;
    localparam int IDX_W = $clog2(NBANK);

    localparam psr_t PSR_RESET = '{mode: M_SVC, i: 1'b1, f: 1'b1};
    localparam psr_t PSR_BLANK = '{mode: M_USR, i: 1'b0, f: 1'b0};

    function automatic logic [IDX_W-1:0] bank_idx(mode_e m);
        case (m)
            M_FIQ:   return IDX_W'(0);
            M_IRQ:   return IDX_W'(1);
            M_SVC:   return IDX_W'(2);
            M_ABT:   return IDX_W'(3);
            M_UND:   return IDX_W'(4);
            default: return IDX_W'(0);
        endcase
    endfunction

    function automatic logic [4:0] vec_off(exc_e x);
        case (x)
            X_UND:   return 5'h04;
            X_SWI:   return 5'h08;
            X_PABT:  return 5'h0C;
            X_DABT:  return 5'h10;
            X_IRQ:   return 5'h18;
            X_FIQ:   return 5'h1C;
            default: return 5'h00;
        endcase
    endfunction

    function automatic mode_e entry_mode(exc_e x);
        case (x)
            X_UND:         return M_UND;
            X_PABT, X_DABT: return M_ABT;
            X_IRQ:         return M_IRQ;
            X_FIQ:         return M_FIQ;
            default:       return M_SVC;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_pkg::*;
(
    input  logic  rst_pend,
    input  logic  chain,
    input  logic  rq_dabt,
    input  logic  rq_fiq,
    input  logic  rq_irq,
    input  logic  rq_pabt,
    input  logic  rq_und,
    input  logic  rq_swi,
    input  psr_t  cur,
    output exc_e  sel,
    output logic  chain_next
);
    always_comb begin
        sel        = X_NONE;
        chain_next = 1'b0;
        if (rst_pend)                 sel = X_RST;
        else if (chain)               sel = X_FIQ;
        else if (rq_dabt) begin
            sel        = X_DABT;
            chain_next = rq_fiq && !cur.f;
        end
        else if (rq_fiq && !cur.f)    sel = X_FIQ;
        else if (rq_irq && !cur.i)    sel = X_IRQ;
        else if (rq_pabt)             sel = X_PABT;
        else if (rq_und)              sel = X_UND;
        else if (rq_swi)              sel = X_SWI;
    end
endmodule

// File: rtl/exc_spsr_bank.sv
module exc_spsr_bank
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  psr_t             wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output psr_t             rd_data
);
    psr_t bank_q [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 bank_q[g] <= PSR_BLANK;
            else if (wr_en && wr_idx == IDX_W'(g))      bank_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = PSR_BLANK;
        for (int k = 0; k < NBANK; k++)
            if (rd_idx == IDX_W'(k)) rd_data = bank_q[k];
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_dabt,
    input  logic             req_fiq,
    input  logic             req_irq,
    input  logic             req_pabt,
    input  logic             req_und,
    input  logic             req_swi,
    input  logic             exc_ret,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [4:0]       mode_o,
    output logic             imask_o,
    output logic             fmask_o
);
    typedef struct packed {
        psr_t             psr;
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             rst_pend;
        logic             chain;
    } state_t;

    state_t           st_d, st_q;
    exc_e             sel;
    logic             chain_next;
    logic             bk_we;
    logic [IDX_W-1:0] bk_widx, bk_ridx;
    psr_t             bk_wdata, bk_rdata;

    exc_prio_sel u_sel (
        .rst_pend  (st_q.rst_pend),
        .chain     (st_q.chain),
        .rq_dabt   (req_dabt),
        .rq_fiq    (req_fiq),
        .rq_irq    (req_irq),
        .rq_pabt   (req_pabt),
        .rq_und    (req_und),
        .rq_swi    (req_swi),
        .cur       (st_q.psr),
        .sel       (sel),
        .chain_next(chain_next)
    );

    exc_spsr_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bk_we),
        .wr_idx (bk_widx),
        .wr_data(bk_wdata),
        .rd_idx (bk_ridx),
        .rd_data(bk_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        bk_we     = 1'b0;
        bk_widx   = bank_idx(entry_mode(sel));
        bk_wdata  = st_q.psr;
        bk_ridx   = bank_idx(st_q.psr.mode);
        if (sel != X_NONE) begin
            st_d.take     = 1'b1;
            st_d.vec      = VEC_W'(vec_off(sel));
            st_d.psr.mode = entry_mode(sel);
            st_d.psr.i    = 1'b1;
            st_d.psr.f    = (sel == X_RST || sel == X_FIQ) ? 1'b1 : st_q.psr.f;
            st_d.rst_pend = 1'b0;
            st_d.chain    = chain_next;
            bk_we         = (sel != X_RST);
        end else if (exc_ret && st_q.psr.mode != M_USR) begin
            st_d.psr = bk_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.psr      <= PSR_RESET;
            st_q.take     <= 1'b0;
            st_q.vec      <= '0;
            st_q.rst_pend <= 1'b1;
            st_q.chain    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o  = st_q.take;
    assign vec_o   = st_q.vec;
    assign mode_o  = st_q.psr.mode;
    assign imask_o = st_q.psr.i;
    assign fmask_o = st_q.psr.f;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int VEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_fiq,
    input logic             take_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [4:0]       mode_o,
    input logic             imask_o,
    input logic             fmask_o
);
    p_no_reserved_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> vec_o != VEC_W'(5'h14));

    p_entry_sets_imask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> imask_o);

    p_irq_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_W'(5'h18)) |-> mode_o == 5'h12);

    p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == '0) |-> (mode_o == 5'h13 && imask_o && fmask_o));

    p_chain_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_W'(5'h10) && $past(req_fiq) && !$past(fmask_o))
        |=> (take_o && vec_o == VEC_W'(5'h1C)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.VEC_W(VEC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_fiq(req_fiq),
    .take_o (take_o),
    .vec_o  (vec_o),
    .mode_o (mode_o),
    .imask_o(imask_o),
    .fmask_o(fmask_o)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
    localparam int VEC_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_dabt = 0, req_fiq = 0, req_irq = 0, req_pabt = 0, req_und = 0, req_swi = 0;
    logic exc_ret = 0;
    logic             take_o;
    logic [VEC_W-1:0] vec_o;
    logic [4:0]       mode_o;
    logic             imask_o, fmask_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    exc_entry_ctrl #(.VEC_W(VEC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
        .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
        .exc_ret(exc_ret), .take_o(take_o), .vec_o(vec_o),
        .mode_o(mode_o), .imask_o(imask_o), .fmask_o(fmask_o)
    );

    // request bit positions used by step(): 5 dabt, 4 fiq, 3 irq, 2 pabt, 1 und, 0 swi
    localparam logic [5:0] Q_DABT = 6'b100000, Q_FIQ = 6'b010000, Q_IRQ = 6'b001000,
                           Q_PABT = 6'b000100, Q_UND = 6'b000010, Q_SWI = 6'b000001;

    // bench model
    logic [4:0] m_mode;
    logic       m_i, m_f, m_take, m_rpend, m_chain;
    logic [4:0] m_vec;
    logic [6:0] m_bank [5];

    function automatic int bidx(logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 5'h13; m_i = 1; m_f = 1; m_take = 0; m_vec = 0;
        m_rpend = 1; m_chain = 0;
        for (int k = 0; k < 5; k++) m_bank[k] = {5'h10, 2'b00};
    endtask

    task automatic enter(logic [4:0] v, logic [4:0] md, logic setf, logic save);
        if (save) m_bank[bidx(md)] = {m_mode, m_i, m_f};
        m_take = 1; m_vec = v; m_mode = md; m_i = 1;
        if (setf) m_f = 1;
    endtask

    task automatic model_step(logic [5:0] r, logic ret);
        logic fiq_ok;
        fiq_ok = r[4] && !m_f;
        m_take = 0;
        if (m_rpend) begin
            enter(5'h00, 5'h13, 1, 0); m_rpend = 0; m_chain = 0;
        end else if (m_chain) begin
            enter(5'h1C, 5'h11, 1, 1); m_chain = 0;
        end else if (r[5]) begin
            enter(5'h10, 5'h17, 0, 1); m_chain = fiq_ok;
        end else if (fiq_ok)        enter(5'h1C, 5'h11, 1, 1);
        else if (r[3] && !m_i)      enter(5'h18, 5'h12, 0, 1);
        else if (r[2])              enter(5'h0C, 5'h17, 0, 1);
        else if (r[1])              enter(5'h04, 5'h1B, 0, 1);
        else if (r[0])              enter(5'h08, 5'h13, 0, 1);
        else if (ret && m_mode != 5'h10) {m_mode, m_i, m_f} = m_bank[bidx(m_mode)];
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R11 take strobe", 32'(take_o), 32'(m_take));
        if (m_take) begin
            chk("R2 vector", vec_o, 32'(m_vec));
            chk("R10 reserved vector absent", 32'(vec_o == 32'h14), 32'h0);
        end
        chk("R3 mode", 32'(mode_o), 32'(m_mode));
        chk("R5 I mask", 32'(imask_o), 32'(m_i));
        chk("R5 F mask", 32'(fmask_o), 32'(m_f));
    endtask

    // called at a negedge
    task automatic step(logic [5:0] r, logic ret);
        {req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi} = r;
        exc_ret = ret;
        model_step(r, ret);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 0;
        {req_dabt, req_fiq, req_irq, req_pabt, req_und, req_swi, exc_ret} = '0;
        model_reset();
        #1;
        chk("R1 reset take low", 32'(take_o), 0);
        chk("R1 reset mode", 32'(mode_o), 32'h13);
        chk("R1 reset masks", 32'({imask_o, fmask_o}), 32'h3);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        step(0, 0);
        chk("R1 reset entry vector", vec_o, 32'h0);

        // R8: return from supervisor to the blank user status
        step(0, 1);
        chk("R8 return to user", 32'(mode_o), 32'h10);

        // R4, R9: fast interrupt beats prefetch abort; the held abort follows
        step(Q_FIQ | Q_PABT, 0);
        chk("R4 fiq over pabt", vec_o, 32'h1C);
        step(Q_PABT, 0);
        chk("R9 held pabt served", vec_o, 32'h0C);
        step(0, 1);
        step(0, 1);
        chk("R8 nested returns reach user", 32'(mode_o), 32'h10);
        chk("R7 user masks restored", 32'({imask_o, fmask_o}), 32'h0);

        // R6: chained entry after data abort
        step(Q_DABT | Q_FIQ | Q_IRQ, 0);
        chk("R6 abort first", vec_o, 32'h10);
        step(0, 0);
        chk("R6 chained fiq", vec_o, 32'h1C);
        chk("R6 chained fiq mode", 32'(mode_o), 32'h11);
        step(0, 1);
        chk("R7 abort context restored", 32'(mode_o), 32'h17);
        chk("R7 abort F clear", 32'(fmask_o), 32'h0);
        step(0, 1);

        // R5: masked normal interrupt ignored after a software call entry
        step(Q_SWI, 0);
        step(Q_IRQ, 0);
        chk("R5 masked irq ignored", 32'(take_o), 0);
        // R8: return in the same cycle as an entry is ignored
        step(Q_UND, 1);
        chk("R8 entry wins over return", 32'(mode_o), 32'h1B);
        step(0, 1);
        step(0, 1);

        // R1: reset between abort and chained fiq cancels the chain
        step(Q_DABT | Q_FIQ, 0);
        do_reset();
        step(0, 0);
        chk("R1 reset overrides chain", vec_o, 32'h0);
        step(0, 0);
        chk("R1 no chained entry after reset", 32'(take_o), 0);
        // R5: fast interrupt masked after reset
        step(Q_FIQ, 0);
        chk("R5 masked fiq ignored", 32'(take_o), 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] r;
            r = '0;
            for (int b = 0; b < 6; b++) r[b] = ($urandom % 7) == 0;
            if (r[1] && r[0]) r[0] = 0;
            step(r, ($urandom % 3) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule